// File: doc/BRIEF.md
# Section-Mode Translation Table Walker

This block turns a 32-bit virtual address into a physical address with a single-level lookup of 1 MB sections. Software first loads a table base register. After that, each request drives one descriptor read on a small memory-read port. The address of that read is formed from the base and the top twelve bits of the virtual address. The returned 32-bit descriptor is decoded into a physical address, a domain number, access-permission bits and the two cacheability bits. A downstream permission checker consumes these values.

Only one walk is in flight at a time. A request is taken only while the walker is idle and the base has been written. The walker stays busy until its response has been handed over. A descriptor that maps nothing, or that names a second-level table, comes back as a fault with a code that tells the two cases apart.

Top module: `sect_walker`

## Requirements
- R1: After reset, `req_ready`, `busy`, `mem_req_valid` and `rsp_valid` are all low, and the table base is zero.
- R2: Until the first `base_wr_en` pulse, `req_ready` stays low, so `req_valid` has no effect and no descriptor read is started.
- R3: A base write keeps `base_wr_data[31:14]` and discards bits [13:0]. The descriptor read address is {base[31:14], vaddr[31:20], 2'b00}.
- R4: A base write in the same cycle that a request is accepted does not affect that request. The new base is used from the next accepted request on. This also holds for a write made while a walk is running.
- R5: `mem_req_valid` stays high with `mem_req_addr` unchanged until a cycle with `mem_req_ready` high.
- R6: For descriptor type bits [1:0] = 2'b10 (section), `rsp_paddr` = {desc[31:20], vaddr[19:0]}. In that case `rsp_fault` = 0 and `rsp_fault_kind` = 0.
- R7: For a section, the field outputs are `rsp_domain` = desc[8:5], `rsp_ap` = desc[11:10], `rsp_c` = desc[3] and `rsp_b` = desc[2].
- R8: For type 2'b00, `rsp_fault` = 1 and `rsp_fault_kind` = 1 (unmapped). `rsp_paddr`, `rsp_domain`, `rsp_ap`, `rsp_c` and `rsp_b` are all zero.
- R9: For type 2'b01 or 2'b11, `rsp_fault` = 1 and `rsp_fault_kind` = 2 (unsupported table type). The other response fields are zero.
- R10: `rsp_valid` stays high, with all response fields unchanged, until a cycle with `rsp_ready` high. `rsp_valid` drops in the cycle after that handshake.
- R11: `busy` is high from the cycle after a request is accepted through the cycle of the response handshake. `req_ready` is low whenever `busy` is high.
- R12: `mem_req_valid` rises in the cycle after request acceptance. `rsp_valid` rises in the cycle after `mem_rsp_valid`. Values on `mem_rsp_data` in other cycles are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| base_wr_en | input | 1 | Load the table base register |
| base_wr_data | input | 32 | New table base; bits [13:0] are discarded |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker can take a request |
| req_vaddr | input | 32 | Virtual address to translate |
| mem_req_valid | output | 1 | Descriptor read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 32 | Byte address of the descriptor |
| mem_rsp_valid | input | 1 | Descriptor data present |
| mem_rsp_data | input | 32 | Descriptor word |
| rsp_valid | output | 1 | Translation result present |
| rsp_ready | input | 1 | Consumer takes the result |
| rsp_paddr | output | 32 | Physical address |
| rsp_domain | output | 4 | Domain number of the section |
| rsp_ap | output | 2 | Access-permission bits |
| rsp_c | output | 1 | Cacheable bit |
| rsp_b | output | 1 | Bufferable bit |
| rsp_fault | output | 1 | Translation fault |
| rsp_fault_kind | output | 2 | 0 none, 1 unmapped, 2 unsupported table type |
| busy | output | 1 | A walk is in progress |

## Verification
A table base write and the acceptance of a request can happen in the same cycle. The ordering between them then decides which base forms the descriptor address. The bench provokes this by driving `base_wr_en` in the same cycle that `req_valid` meets `req_ready`, and again by writing the base while a walk is running. It judges the result from the observed `mem_req_addr`. That address must still carry the old base, and the following request must carry the new one.

// File: rtl/sw_pkg.sv
package sw_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_WAIT  = 2'd2,
        ST_RESP  = 2'd3
    } sw_state_e;

    typedef enum logic [1:0] {
        FK_NONE     = 2'd0,
        FK_UNMAPPED = 2'd1,
        FK_UNSUPP   = 2'd2
    } sw_fault_e;

    // descriptor type codes in bits [1:0]
    localparam logic [1:0] DT_FAULT   = 2'b00;
    localparam logic [1:0] DT_SECTION = 2'b10;

    // field positions inside a section descriptor
    localparam int DSC_B_BIT   = 2;
    localparam int DSC_C_BIT   = 3;
    localparam int DSC_DOM_LSB = 5;
    localparam int DSC_DOM_W   = 4;
    localparam int DSC_AP_LSB  = 10;
    localparam int DSC_AP_W    = 2;

endpackage

// File: rtl/sw_base_reg.sv
module sw_base_reg #(
    parameter int ADDR_W  = 32,
    parameter int ALIGN_W = 14
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [ADDR_W-1:0]         wr_data,
    output logic [ADDR_W-ALIGN_W-1:0] base_hi,
    output logic                      loaded
);

    typedef struct packed {
        logic [ADDR_W-ALIGN_W-1:0] hi;
        logic                      loaded;
    } base_t;

    base_t base_d, base_q;

    logic [ALIGN_W-1:0] unused_low;
    assign unused_low = wr_data[ALIGN_W-1:0];

    always_comb begin
        base_d = base_q;
        if (wr_en) begin
            base_d.hi     = wr_data[ADDR_W-1:ALIGN_W];
            base_d.loaded = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q <= '0;
        end else begin
            base_q <= base_d;
        end
    end

    assign base_hi = base_q.hi;
    assign loaded  = base_q.loaded;

endmodule

// File: rtl/sw_desc_decode.sv
module sw_desc_decode
    import sw_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int OFS_W  = 20
) (
    input  logic [ADDR_W-1:0]    desc,
    input  logic [OFS_W-1:0]     offset,
    output logic [ADDR_W-1:0]    paddr,
    output logic [DSC_DOM_W-1:0] domain,
    output logic [DSC_AP_W-1:0]  ap,
    output logic                 c_bit,
    output logic                 b_bit,
    output sw_fault_e            kind
);

    // bits the section format leaves without meaning here
    logic unused_bits;
    assign unused_bits = ^{desc[OFS_W-1:DSC_AP_LSB+DSC_AP_W], desc[DSC_DOM_LSB-1], desc[DSC_AP_LSB-1]};

    always_comb begin
        paddr  = '0;
        domain = '0;
        ap     = '0;
        c_bit  = 1'b0;
        b_bit  = 1'b0;
        kind   = FK_NONE;
        case (desc[1:0])
            DT_SECTION: begin
                paddr  = {desc[ADDR_W-1:OFS_W], offset};
                domain = desc[DSC_DOM_LSB +: DSC_DOM_W];
                ap     = desc[DSC_AP_LSB +: DSC_AP_W];
                c_bit  = desc[DSC_C_BIT];
                b_bit  = desc[DSC_B_BIT];
            end
            DT_FAULT: kind = FK_UNMAPPED;
            default:  kind = FK_UNSUPP;
        endcase
    end

endmodule

// File: rtl/sect_walker.sv
module sect_walker
    import sw_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int IDX_W      = 12,
    parameter int DESC_BYTES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              base_wr_en,
    input  logic [ADDR_W-1:0] base_wr_data,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_vaddr,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [ADDR_W-1:0] mem_req_addr,
    input  logic              mem_rsp_valid,
    input  logic [ADDR_W-1:0] mem_rsp_data,
    output logic              rsp_valid,
    input  logic              rsp_ready,
    output logic [ADDR_W-1:0] rsp_paddr,
    output logic [3:0]        rsp_domain,
    output logic [1:0]        rsp_ap,
    output logic              rsp_c,
    output logic              rsp_b,
    output logic              rsp_fault,
    output logic [1:0]        rsp_fault_kind,
    output logic              busy
);

    localparam int OFS_W   = ADDR_W - IDX_W;
    localparam int DSC_LSB = $clog2(DESC_BYTES);
    localparam int ALIGN_W = IDX_W + DSC_LSB;
    localparam int HI_W    = ADDR_W - ALIGN_W;

    typedef struct packed {
        sw_state_e                st;
        logic [ADDR_W-1:0]        faddr;
        logic [OFS_W-1:0]         ofs;
        logic [ADDR_W-1:0]        paddr;
        logic [DSC_DOM_W-1:0]     dom;
        logic [DSC_AP_W-1:0]      ap;
        logic                     c;
        logic                     b;
        sw_fault_e                kind;
    } walk_t;

    walk_t w_d, w_q;

    logic [HI_W-1:0]      base_hi;
    logic                 base_loaded;
    logic [ADDR_W-1:0]    dec_paddr;
    logic [DSC_DOM_W-1:0] dec_dom;
    logic [DSC_AP_W-1:0]  dec_ap;
    logic                 dec_c;
    logic                 dec_b;
    sw_fault_e            dec_kind;
    logic                 take_req;

    sw_base_reg #(
        .ADDR_W (ADDR_W),
        .ALIGN_W(ALIGN_W)
    ) base_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (base_wr_en),
        .wr_data(base_wr_data),
        .base_hi(base_hi),
        .loaded (base_loaded)
    );

    sw_desc_decode #(
        .ADDR_W(ADDR_W),
        .OFS_W (OFS_W)
    ) dec_i (
        .desc  (mem_rsp_data),
        .offset(w_q.ofs),
        .paddr (dec_paddr),
        .domain(dec_dom),
        .ap    (dec_ap),
        .c_bit (dec_c),
        .b_bit (dec_b),
        .kind  (dec_kind)
    );

    assign req_ready = (w_q.st == ST_IDLE) && base_loaded;
    assign take_req  = req_valid && req_ready;

    always_comb begin
        w_d = w_q;
        case (w_q.st)
            ST_IDLE: begin
                if (take_req) begin
                    w_d.st    = ST_ISSUE;
                    w_d.faddr = {base_hi, req_vaddr[ADDR_W-1:OFS_W], {DSC_LSB{1'b0}}};
                    w_d.ofs   = req_vaddr[OFS_W-1:0];
                end
            end
            ST_ISSUE: begin
                if (mem_req_ready) begin
                    w_d.st = ST_WAIT;
                end
            end
            ST_WAIT: begin
                if (mem_rsp_valid) begin
                    w_d.st    = ST_RESP;
                    w_d.paddr = dec_paddr;
                    w_d.dom   = dec_dom;
                    w_d.ap    = dec_ap;
                    w_d.c     = dec_c;
                    w_d.b     = dec_b;
                    w_d.kind  = dec_kind;
                end
            end
            default: begin
                if (rsp_ready) begin
                    w_d.st = ST_IDLE;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            w_q <= '0;
        end else begin
            w_q <= w_d;
        end
    end

    assign busy           = (w_q.st != ST_IDLE);
    assign mem_req_valid  = (w_q.st == ST_ISSUE);
    assign mem_req_addr   = w_q.faddr;
    assign rsp_valid      = (w_q.st == ST_RESP);
    assign rsp_paddr      = w_q.paddr;
    assign rsp_domain     = w_q.dom;
    assign rsp_ap         = w_q.ap;
    assign rsp_c          = w_q.c;
    assign rsp_b          = w_q.b;
    assign rsp_fault_kind = w_q.kind;
    assign rsp_fault      = (w_q.kind != FK_NONE);

endmodule

// File: rtl/sw_walker_chk.sv
module sw_walker_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              base_wr_en,
    input logic              req_valid,
    input logic              req_ready,
    input logic              busy,
    input logic              mem_req_valid,
    input logic              mem_req_ready,
    input logic [ADDR_W-1:0] mem_req_addr,
    input logic              mem_rsp_valid,
    input logic              rsp_valid,
    input logic              rsp_ready,
    input logic [ADDR_W-1:0] rsp_paddr,
    input logic [3:0]        rsp_domain,
    input logic [1:0]        rsp_ap,
    input logic              rsp_c,
    input logic              rsp_b,
    input logic [1:0]        rsp_fault_kind
);

    logic seen_wr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen_wr_q <= 1'b0;
        end else if (base_wr_en) begin
            seen_wr_q <= 1'b1;
        end
    end

    // R2
    no_early_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !seen_wr_q |-> !req_ready);

    // R11
    busy_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !req_ready);

    // R12
    accept_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (busy && mem_req_valid));

    // R5
    mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

    // R10
    rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_paddr) && $stable(rsp_domain)
                                       && $stable(rsp_ap) && $stable(rsp_fault_kind)));

    // R8
    fault_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault_kind == 2'd1) |->
            (rsp_paddr == '0 && rsp_domain == 4'd0 && rsp_ap == 2'd0 && !rsp_c && !rsp_b));

    // R12
    data_to_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rsp_valid && busy && !mem_req_valid && !rsp_valid) |=> rsp_valid);

endmodule

bind sect_walker sw_walker_chk #(.ADDR_W(ADDR_W)) chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .base_wr_en    (base_wr_en),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .busy          (busy),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_addr  (mem_req_addr),
    .mem_rsp_valid (mem_rsp_valid),
    .rsp_valid     (rsp_valid),
    .rsp_ready     (rsp_ready),
    .rsp_paddr     (rsp_paddr),
    .rsp_domain    (rsp_domain),
    .rsp_ap        (rsp_ap),
    .rsp_c         (rsp_c),
    .rsp_b         (rsp_b),
    .rsp_fault_kind(rsp_fault_kind)
);

// File: tb/sect_walker_tb_top.sv
`timescale 1ns/1ps
module sect_walker_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        base_wr_en = 1'b0;
    logic [31:0] base_wr_data = '0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_vaddr = '0;
    logic        mem_req_valid;
    logic        mem_req_ready = 1'b0;
    logic [31:0] mem_req_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_data = '0;
    logic        rsp_valid;
    logic        rsp_ready = 1'b0;
    logic [31:0] rsp_paddr;
    logic [3:0]  rsp_domain;
    logic [1:0]  rsp_ap;
    logic        rsp_c;
    logic        rsp_b;
    logic        rsp_fault;
    logic [1:0]  rsp_fault_kind;
    logic        busy;

    always #2.5 clk = ~clk;

    sect_walker dut_i (
        .clk(clk), .rst_n(rst_n),
        .base_wr_en(base_wr_en), .base_wr_data(base_wr_data),
        .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_paddr(rsp_paddr),
        .rsp_domain(rsp_domain), .rsp_ap(rsp_ap), .rsp_c(rsp_c), .rsp_b(rsp_b),
        .rsp_fault(rsp_fault), .rsp_fault_kind(rsp_fault_kind), .busy(busy)
    );

    int total = 0;
    int bad = 0;
    bit finished = 0;

    // reference model state: 0 idle, 1 read issued, 2 waiting data, 3 result held
    int          m_phase = 0;
    int          m_ctr = 0;
    bit          m_loaded = 0;
    logic [31:0] m_base = '0;
    logic [31:0] m_addr = '0;
    logic [31:0] m_va = '0;
    logic [42:0] m_exp = '0;
    int          m_kind = 0;
    int          done_cnt = 0;

    bit          want_req = 0;
    logic [31:0] want_va = '0;
    bit          wr_req = 0;
    logic [31:0] wr_val = '0;
    int          rdy_lat = 0;
    int          dat_lat = 0;
    int          ack_lat = 0;
    string       addr_tag = "R3";

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [31:0] mem_word(input logic [31:0] a);
        logic [11:0] idx;
        logic [31:0] h;
        logic [1:0]  ty;
        idx = a[13:2];
        h = ({20'h0, idx} * 32'h9E37_79B1) ^ 32'h5A3C_0F96;
        case (idx[1:0])
            2'd0:    ty = 2'b10;
            2'd1:    ty = 2'b00;
            2'd2:    ty = 2'b01;
            default: ty = 2'b11;
        endcase
        return {h[31:2], ty};
    endfunction

    // packing: {paddr, domain, ap, c, b, fault_kind, fault}
    function automatic logic [42:0] expect_of(input logic [31:0] w, input logic [31:0] va,
                                              output int kind);
        if (w[1:0] == 2'b10) begin
            kind = 0;
            return {w[31:20], va[19:0], w[8:5], w[11:10], w[3], w[2], 2'd0, 1'b0};
        end else if (w[1:0] == 2'b00) begin
            kind = 1;
            return {40'h0, 2'd1, 1'b1};
        end else begin
            kind = 2;
            return {40'h0, 2'd2, 1'b1};
        end
    endfunction

    task automatic tick();
        bit acc;
        @(negedge clk);
        // compare outputs against the model
        check(m_loaded ? "R11" : "R2", {63'h0, req_ready}, {63'h0, (m_phase == 0 && m_loaded)});
        check("R11", {63'h0, busy}, {63'h0, (m_phase != 0)});
        check("R12", {63'h0, mem_req_valid}, {63'h0, (m_phase == 1)});
        if (m_phase == 1)
            check((m_ctr > 0) ? "R5" : addr_tag, {32'h0, mem_req_addr}, {32'h0, m_addr});
        check("R10", {63'h0, rsp_valid}, {63'h0, (m_phase == 3)});
        if (m_phase == 3)
            check((m_kind == 0) ? "R6/R7" : ((m_kind == 1) ? "R8" : "R9"),
                  {21'h0, rsp_paddr, rsp_domain, rsp_ap, rsp_c, rsp_b, rsp_fault_kind, rsp_fault},
                  {21'h0, m_exp});
        // drive inputs for the coming edge
        base_wr_en    = wr_req;
        base_wr_data  = wr_val;
        wr_req        = 0;
        req_valid     = want_req;
        req_vaddr     = want_va;
        mem_req_ready = (m_phase == 1) && (m_ctr >= rdy_lat);
        mem_rsp_valid = (m_phase == 2) && (m_ctr >= dat_lat);
        mem_rsp_data  = mem_rsp_valid ? mem_word(m_addr) : 32'hDEAD_BEEF;
        rsp_ready     = (m_phase == 3) && (m_ctr >= ack_lat);
        // advance the model by what that edge will do
        acc = 0;
        case (m_phase)
            0: if (req_valid && m_loaded && rst_n) begin
                   m_addr  = {m_base[31:14], req_vaddr[31:20], 2'b00};
                   m_va    = req_vaddr;
                   m_phase = 1; m_ctr = 0; want_req = 0;
               end
            1: if (mem_req_ready) begin m_phase = 2; m_ctr = 0; end else m_ctr++;
            2: if (mem_rsp_valid) begin
                   m_exp = expect_of(mem_rsp_data, m_va, m_kind);
                   m_phase = 3; m_ctr = 0;
               end else m_ctr++;
            default: if (rsp_ready) begin m_phase = 0; acc = 1; end else m_ctr++;
        endcase
        if (acc) done_cnt++;
        if (base_wr_en && rst_n) begin
            m_base   = base_wr_data & 32'hFFFF_C000;
            m_loaded = 1;
        end
    endtask

    task automatic walk(input logic [31:0] va, input int wr_at, input logic [31:0] wv);
        int start;
        int n;
        start = done_cnt;
        n = 0;
        want_req = 1;
        want_va = va;
        while (done_cnt == start && n < 500) begin
            if (n == wr_at) begin
                wr_req = 1;
                wr_val = wv;
            end
            tick();
            n++;
        end
        if (done_cnt == start) begin
            total++; bad++;
            $display("FAIL watchdog: walk for %h never completed (R11)", va);
            want_req = 0;
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        #500000;
        total++; bad++;
        $display("FAIL watchdog: run timed out");
        finish_run();
    end

    initial begin
        repeat (4) tick();
        @(negedge clk);
        // R1 reset state
        check("R1", {60'h0, req_ready, busy, mem_req_valid, rsp_valid}, 64'h0);
        rst_n = 1'b1;
        repeat (2) tick();

        // R2: requests before any base write are ignored
        want_req = 1; want_va = 32'h3000_0012;
        repeat (8) tick();
        check("R2", 64'(done_cnt), 64'h0);
        want_req = 0;
        tick();

        // R3: low base bits discarded
        wr_req = 1; wr_val = 32'h1234_5FFF;
        tick();
        tick();

        // R6 R7 R8 R9 with all four descriptor types, boundary indices
        walk(32'h3000_0012, -1, 0);
        walk(32'h3010_0ABC, -1, 0);
        walk(32'h3020_0001, -1, 0);
        walk(32'h3030_FFFF, -1, 0);
        walk(32'h0000_0000, -1, 0);
        walk(32'hFFC1_2345, -1, 0);
        walk(32'hFFFF_FFFF, -1, 0);
        walk(32'hFFEF_FFFF, -1, 0);

        // R5 R10 with stalls on both handshakes
        rdy_lat = 3; dat_lat = 2; ack_lat = 4;
        walk(32'h1230_0444, -1, 0);
        walk(32'h1231_0000, -1, 0);
        walk(32'h7FF3_1111, -1, 0);
        rdy_lat = 1; dat_lat = 0; ack_lat = 2;
        walk(32'h0041_2345, -1, 0);

        // R4: base write collides with acceptance, then write during a walk
        rdy_lat = 0; dat_lat = 1; ack_lat = 0;
        addr_tag = "R4";
        walk(32'h4560_0000, 0, 32'hABCD_0000);
        walk(32'h4560_0000, -1, 0);
        walk(32'h89A0_0010, 2, 32'h0F0F_4000);
        walk(32'h89A0_0010, -1, 0);
        addr_tag = "R3";

        // R12 back-to-back walks with no stalls
        rdy_lat = 0; dat_lat = 0; ack_lat = 0;
        for (int i = 0; i < 24; i++) begin
            walk(32'(i) * 32'h00B0_0000 + 32'(i * 7), -1, 0);
        end
        repeat (3) tick();
        finish_run();
    end

endmodule